// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit integer datapath that splits its two operands into independent lanes of equal width. One operation is applied to every lane in the same cycle. The lane width is selected per operation: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Carries and borrows stop at each lane edge, so every lane acts as a separate fixed-point integer.

The block follows a two-operand convention. The caller presents the current destination value and a source value, and the result `dst OP src` is meant to be written back over the destination. Add and subtract can wrap, or they can clamp each lane to its signed or unsigned range. The other operations are lane-wise equality and signed greater-than compares, lane-wise logical and arithmetic shifts, and four full-width bitwise operations. The result is registered and appears one cycle after the request.

Top module: `simd_alu`

## Requirements
- R1: With `sat_i` set to wrap (2'b00 or 2'b11), add (`op_i`=4'd0) returns the low bits of each lane sum. The lane width is set by `lane_sz_i`: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit. No carry passes from one lane into the next.
- R2: Subtract (`op_i`=4'd1) in wrap mode returns `dst - src` modulo 2^n in every lane, and no borrow crosses a lane edge.
- R3: With `sat_i`=2'b10 (unsigned saturation) and 8-bit or 16-bit lanes, add and subtract clamp each lane to the range 0..2^n-1.
- R4: With `sat_i`=2'b01 (signed saturation) and 8-bit or 16-bit lanes, add and subtract clamp each lane to the range -2^(n-1)..2^(n-1)-1.
- R5: With 32-bit or 64-bit lanes, both saturation codes are ignored and add and subtract wrap.
- R6: The bitwise operations work on the full 64 bits: AND (`op_i`=4'd8) gives `dst & src`, AND-NOT (4'd9) gives `~dst & src`, OR (4'd10) gives `dst | src`, and XOR (4'd11) gives `dst ^ src`.
- R7: Compare-equal (`op_i`=4'd2) and signed compare-greater (4'd3, true when `dst > src`) fill each lane with all ones when the condition holds and with all zeros when it does not.
- R8: Shift-left logical (`op_i`=4'd4) and shift-right logical (4'd5) move every lane by the unsigned count `src_i[7:0]`. A count equal to or larger than the lane width gives a zero lane.
- R9: Shift-right arithmetic (`op_i`=4'd6) moves every lane right by `src_i[7:0]` and fills the vacated bits with the lane's sign bit. A count equal to or larger than the lane width fills the whole lane with the sign bit.
- R10: `valid_o` and `result_o` reflect a request one clock after `valid_i` is high. While `valid_i` is low, `result_o` keeps its value.
- R11: While `rst_ni` is low, `result_o` is zero and `valid_o` is low.
- R12: The unassigned opcodes 4'd7 and 4'd12..4'd15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| lane_sz_i | input | 2 | Lane width select |
| sat_i | input | 2 | Wrap / signed / unsigned saturation select |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand |
| valid_o | output | 1 | Result valid, one cycle after request |
| result_o | output | 64 | Registered result |

## Verification
The assertions assume that the control inputs are driven to known values on every clock edge where `valid_i` is high. They make no assumption about idle cycles, because the hold property covers cycles whose inputs are arbitrary. The stimulus therefore changes operands and controls while `valid_i` is low, and the hold property is checked under that changing input. The bench changes its inputs only on the falling edge, and it mixes directed corner values with random opcodes, including the unassigned codes.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CEQ  = 4'd2,
    OP_CGT  = 4'd3,
    OP_SHL  = 4'd4,
    OP_SHR  = 4'd5,
    OP_SAR  = 4'd6,
    OP_AND  = 4'd8,
    OP_ANDN = 4'd9,
    OP_OR   = 4'd10,
    OP_XOR  = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    SAT_WRAP = 2'd0,
    SAT_S    = 2'd1,
    SAT_U    = 2'd2,
    SAT_WRP2 = 2'd3
  } sat_mode_e;

  localparam int NUM_SIZES = 4;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W      = 8,
  parameter bit SAT_OK = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic [1:0]   sat_i,
  input  logic [7:0]   cnt_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] UMAX = '1;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] uadd, usub, sadd, ssub;
  logic [W-1:0] add_r, sub_r, shl_r, shr_r, sar_r;
  logic big;

  assign uadd = {1'b0, a_i} + {1'b0, b_i};
  assign usub = {1'b0, a_i} - {1'b0, b_i};
  assign sadd = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign ssub = {a_i[W-1], a_i} - {b_i[W-1], b_i};
  assign big  = 32'(cnt_i) >= W;

  always_comb begin
    add_r = uadd[W-1:0];
    sub_r = usub[W-1:0];
    if (SAT_OK && sat_i == SAT_U) begin
      add_r = uadd[W] ? UMAX : uadd[W-1:0];
      sub_r = usub[W] ? '0 : usub[W-1:0];
    end else if (SAT_OK && sat_i == SAT_S) begin
      if (sadd[W] != sadd[W-1]) add_r = sadd[W] ? SMIN : SMAX;
      else                      add_r = sadd[W-1:0];
      if (ssub[W] != ssub[W-1]) sub_r = ssub[W] ? SMIN : SMAX;
      else                      sub_r = ssub[W-1:0];
    end
  end

  always_comb begin
    if (big) begin
      shl_r = '0;
      shr_r = '0;
      sar_r = {W{a_i[W-1]}};
    end else begin
      shl_r = a_i << cnt_i;
      shr_r = a_i >> cnt_i;
      sar_r = W'($signed(a_i) >>> cnt_i);
    end
  end

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = add_r;
      OP_SUB:  res_o = sub_r;
      OP_CEQ:  res_o = {W{a_i == b_i}};
      OP_CGT:  res_o = {W{$signed(a_i) > $signed(b_i)}};
      OP_SHL:  res_o = shl_r;
      OP_SHR:  res_o = shr_r;
      OP_SAR:  res_o = sar_r;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_logic.sv
module simd_logic
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_ANDN: res_o = ~a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MIN_W  = 8,
  parameter int SAT_MAX_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        lane_sz_i,
  input  logic [1:0]        sat_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int NBYTE = DATA_W / 8;

  logic [DATA_W-1:0] lane_res [NUM_SIZES];
  logic [DATA_W-1:0] logic_res, nxt_res;

  // one lane array per width; lane_sz_i picks among them
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int W  = MIN_W << g;
    localparam int NL = DATA_W / W;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane #(.W(W), .SAT_OK(W <= SAT_MAX_W)) u_lane (
        .a_i  (dst_i[l*W +: W]),
        .b_i  (src_i[l*W +: W]),
        .op_i (op_i),
        .sat_i(sat_i),
        .cnt_i(src_i[7:0]),
        .res_o(lane_res[g][l*W +: W])
      );
    end
  end

  simd_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i  (dst_i),
    .b_i  (src_i),
    .op_i (op_i),
    .res_o(logic_res)
  );

  assign nxt_res = op_i[3] ? logic_res : lane_res[lane_sz_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt_res;
    end
  end

  function automatic bit bytes_mask(input logic [DATA_W-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < NBYTE; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hff) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit bytes_ge(input logic [DATA_W-1:0] r, input logic [DATA_W-1:0] d);
    bit ok = 1'b1;
    for (int i = 0; i < NBYTE; i++)
      if (r[i*8 +: 8] < d[i*8 +: 8]) ok = 1'b0;
    return ok;
  endfunction

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  assert_usat_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD && sat_i == SAT_U && lane_sz_i == 2'd0)
    |=> bytes_ge(result_o, $past(dst_i)));

  assert_cmp_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_CEQ || op_i == OP_CGT) && lane_sz_i == 2'd0)
    |=> bytes_mask(result_o));

  assert_big_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_SHL || op_i == OP_SHR) && src_i[7:0] >= 8'(DATA_W))
    |=> result_o == '0);

  assert_bad_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd7 || op_i >= 4'd12)) |=> result_o == '0);
endmodule

// File: tb/simd_alu_tb.sv
`timescale 1ns/1ps
module simd_alu_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] ls = '0, sat = '0;
  logic [63:0] d = '0, s = '0;
  logic valid_q;
  logic [63:0] res;
  int total = 0, bad = 0, cyc = 0;
  logic [63:0] exp_res = '0;
  logic exp_v = 1'b0;

  always #4 clk = ~clk;

  simd_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .lane_sz_i(ls),
    .sat_i(sat), .dst_i(d), .src_i(s), .valid_o(valid_q), .result_o(res)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d cycles expected < 100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic longint sx(input logic [63:0] v, input int w);
    return v[w-1] ? longint'(v) - (longint'(1) << w) : longint'(v);
  endfunction

  function automatic logic [63:0] model(input logic [3:0] o, input logic [1:0] z,
      input logic [1:0] sm, input logic [63:0] a64, input logic [63:0] b64);
    int w = 8 << z;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] out = '0;
    int cnt = int'(b64[7:0]);
    bit satok = (w <= 16);
    case (o)
      4'd8:  return a64 & b64;
      4'd9:  return ~a64 & b64;
      4'd10: return a64 | b64;
      4'd11: return a64 ^ b64;
      default: ;
    endcase
    for (int k = 0; k < 64 / w; k++) begin
      logic [63:0] a = (a64 >> (k * w)) & m;
      logic [63:0] b = (b64 >> (k * w)) & m;
      logic [63:0] r = '0;
      longint t;
      bit neg = a[w-1];
      case (o)
        4'd0, 4'd1: begin
          if (satok && sm == 2'd2) begin
            t = (o == 4'd0) ? longint'(a) + longint'(b) : longint'(a) - longint'(b);
            if (t < 0) t = 0;
            if (t > longint'(m)) t = longint'(m);
            r = 64'(t);
          end else if (satok && sm == 2'd1) begin
            t = (o == 4'd0) ? sx(a, w) + sx(b, w) : sx(a, w) - sx(b, w);
            if (t > (longint'(1) << (w - 1)) - 1) t = (longint'(1) << (w - 1)) - 1;
            if (t < -(longint'(1) << (w - 1))) t = -(longint'(1) << (w - 1));
            r = 64'(t);
          end else r = (o == 4'd0) ? a + b : a - b;
        end
        4'd2: r = (a == b) ? m : '0;
        4'd3: begin
          if (w == 64) r = ($signed(a) > $signed(b)) ? m : '0;
          else r = (sx(a, w) > sx(b, w)) ? m : '0;
        end
        4'd4: r = (cnt >= w) ? '0 : (a << cnt);
        4'd5: r = (cnt >= w) ? '0 : (a >> cnt);
        4'd6: r = (cnt >= w) ? (neg ? m : '0)
                             : ((a >> cnt) | (neg ? (m & ~(m >> cnt)) : 64'd0));
        default: r = '0;
      endcase
      out = out | ((r & m) << (k * w));
    end
    return out;
  endfunction

  task automatic check(input string tag);
    total++;
    if (res !== exp_res || valid_q !== exp_v) begin
      bad++;
      $display("FAIL %s: got v=%0b r=%h expected v=%0b r=%h", tag, valid_q, res, exp_v, exp_res);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] o, input logic [1:0] z,
      input logic [1:0] sm, input logic [63:0] a, input logic [63:0] b, input string tag);
    valid = v; op = o; ls = z; sat = sm; d = a; s = b;
    @(posedge clk);
    if (v) exp_res = model(o, z, sm, a, b);
    exp_v = v;
    @(negedge clk);
    check(tag);
  endtask

  function automatic string tag_of(input logic [3:0] o, input logic [1:0] z, input logic [1:0] sm);
    if (o >= 4'd12 || o == 4'd7) return "R12";
    if (o >= 4'd8) return "R6";
    if (o == 4'd2 || o == 4'd3) return "R7";
    if (o == 4'd6) return "R9";
    if (o == 4'd4 || o == 4'd5) return "R8";
    if (z >= 2'd2 && (sm == 2'd1 || sm == 2'd2)) return "R5";
    if (sm == 2'd2) return "R3";
    if (sm == 2'd1) return "R4";
    return (o == 4'd0) ? "R1" : "R2";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 lane-bounded wrap add
    step(1, 4'd0, 2'd0, 2'd0, 64'h00ff_00ff_00ff_00ff, 64'h0101_0101_0101_0101, "R1 byte wrap");
    step(1, 4'd0, 2'd3, 2'd3, 64'h0000_0000_ffff_ffff, 64'h1, "R1 quad carry");
    step(1, 4'd0, 2'd2, 2'd0, 64'h0000_0000_ffff_ffff, 64'h1, "R1 dword no carry");
    // R2
    step(1, 4'd1, 2'd1, 2'd0, 64'h0, 64'h0001_0000_0001_0000, "R2 word borrow");
    // R3
    step(1, 4'd0, 2'd0, 2'd2, 64'hf0f0_1010_f0f0_1010, 64'h2020_2020_2020_2020, "R3 ubyte add");
    step(1, 4'd1, 2'd1, 2'd2, 64'h0001_0005_0001_0005, 64'h0002_0002_0002_0002, "R3 uword sub");
    // R4
    step(1, 4'd0, 2'd0, 2'd1, 64'h7f80_7f80_7f80_7f80, 64'h01ff_01ff_01ff_01ff, "R4 sbyte add");
    step(1, 4'd1, 2'd1, 2'd1, 64'h8000_7fff_8000_7fff, 64'h0001_ffff_0001_ffff, "R4 sword sub");
    // R5
    step(1, 4'd0, 2'd2, 2'd2, 64'hffff_ffff_ffff_ffff, 64'h0000_0001_0000_0001, "R5 dword usat ignored");
    step(1, 4'd1, 2'd3, 2'd1, 64'h8000_0000_0000_0000, 64'h1, "R5 quad ssat ignored");
    // R6
    step(1, 4'd8, 2'd0, 2'd0, 64'hf0f0_cccc_aaaa_1234, 64'hff00_f0f0_5555_ffff, "R6 and");
    step(1, 4'd9, 2'd1, 2'd0, 64'hf0f0_cccc_aaaa_1234, 64'hff00_f0f0_5555_ffff, "R6 andn");
    step(1, 4'd10, 2'd2, 2'd0, 64'hf0f0_cccc_aaaa_1234, 64'hff00_f0f0_5555_ffff, "R6 or");
    step(1, 4'd11, 2'd3, 2'd0, 64'hf0f0_cccc_aaaa_1234, 64'hff00_f0f0_5555_ffff, "R6 xor");
    // R7
    step(1, 4'd2, 2'd1, 2'd0, 64'h1234_5678_9abc_def0, 64'h1234_0000_9abc_0000, "R7 eq word");
    step(1, 4'd3, 2'd0, 2'd0, 64'h8001_7f05_0080_ff01, 64'h0180_8005_7f00_00ff, "R7 gt byte");
    // R8
    step(1, 4'd4, 2'd2, 2'd0, 64'h8000_0001_1234_5678, 64'h4, "R8 shl dword");
    step(1, 4'd5, 2'd0, 2'd0, 64'hffff_ffff_ffff_ffff, 64'h9, "R8 shr byte big");
    step(1, 4'd5, 2'd3, 2'd0, 64'h8000_0000_0000_0000, 64'h3f, "R8 shr quad 63");
    // R9
    step(1, 4'd6, 2'd1, 2'd0, 64'h8000_7ff0_f00f_0100, 64'h3, "R9 sar word");
    step(1, 4'd6, 2'd2, 2'd0, 64'h8000_0000_7fff_ffff, 64'hc8, "R9 sar big");
    // R10 hold with changing inputs
    step(0, 4'd11, 2'd1, 2'd1, 64'hdead_beef_0000_1111, 64'h5555_aaaa_5555_aaaa, "R10 hold");
    step(0, 4'd0, 2'd0, 2'd2, 64'h0, 64'h0, "R10 hold2");
    // R12
    step(1, 4'd7, 2'd0, 2'd0, 64'h1, 64'h1, "R12 op7");
    step(1, 4'd13, 2'd3, 2'd1, 64'hffff, 64'hffff, "R12 op13");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] o = 4'($urandom);
      logic [1:0] z = 2'($urandom);
      logic [1:0] sm = 2'($urandom);
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      if (i % 3 == 0) b[7:0] = 8'($urandom_range(0, 70));
      step(($urandom % 5) != 0, o, z, sm, a, b, tag_of(o, z, sm));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule